// File: doc/BRIEF.md
# Conditional Branch-to-Link-Register Resolver

This execute-stage block settles a conditional branch whose destination is held in the link register. Each clock it takes the branch option field, the index of a condition bit, the link flag, the addressing mode, the address of the current instruction, the condition register, the count register and the link register. It then produces the address of the next instruction, a taken flag, a new count value and a new link value, each with its own write strobe. All outputs are registered.

Bit numbering is big-endian. Bit 0 of a field is its most significant bit. For the 5-bit option field `bo_i`, option bit k is `bo_i[4-k]`. For the condition register, condition bit `bi` is `cr_i[31-bi]`. Option bit 4 only carries a hint and has no effect on any result.

Top module: `branch_lr_resolver`

## Requirements
- R1: When option bit 2 (`bo_i[2]`) is 0, `ctr_o` is the incoming count minus one, wrapping modulo 2^64, and `ctr_we_o` is 1.
- R2: The count test looks at all 64 bits of the count when `wide_i` is 1. When `wide_i` is 0 it looks only at bits 31:0. The count tested is the decremented value whenever a decrement happens.
- R3: The count test passes when option bit 2 is 1. Otherwise it passes when the tested count bits being nonzero differs from option bit 3 (`bo_i[1]`).
- R4: The condition test passes when option bit 0 (`bo_i[4]`) is 1. Otherwise it passes when condition bit `bi_i` (`cr_i[31-bi_i]`) equals option bit 1 (`bo_i[3]`).
- R5: `taken_o` is 1 exactly when both the count test and the condition test pass.
- R6: On a taken branch, `nia_o` equals the incoming link register with bits 1:0 cleared.
- R7: On a branch that is not taken, `nia_o` equals `cia_i + 4`.
- R8: When `lk_i` is 1, `lr_o` is `cia_i + 4` and `lr_we_o` is 1, whether or not the branch is taken.
- R9: When `lk_i` is 1 and the branch is taken, the target comes from the link value before it is updated, not from `cia_i + 4`.
- R10: While `rst` is high at a clock edge, all outputs become 0 on that edge.
- R11: When option bit 2 is 1, `ctr_o` equals the incoming count and `ctr_we_o` is 0. When `lk_i` is 0, `lr_o` equals the incoming link value and `lr_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bo_i | input | 5 | Branch option field (bo_i[4] is option bit 0) |
| bi_i | input | 5 | Index of the condition bit (0 selects cr_i[31]) |
| lk_i | input | 1 | Write the return address into the link register |
| wide_i | input | 1 | 1 selects the 64-bit count test, 0 selects the 32-bit test |
| cia_i | input | 64 | Current instruction address |
| cr_i | input | 32 | Condition register |
| ctr_i | input | 64 | Count register value |
| lr_i | input | 64 | Link register value |
| nia_o | output | 64 | Next instruction address |
| taken_o | output | 1 | Branch taken |
| ctr_o | output | 64 | New count value |
| ctr_we_o | output | 1 | Count write strobe |
| lr_o | output | 64 | New link value |
| lr_we_o | output | 1 | Link write strobe |

## Verification
Two things can fall in the same cycle. The count decrement can meet the count test, and the link write can meet a taken branch. The bench provokes the first with counts of 1, 0 and 2^32+1 in both modes. In those cases the branch decision changes only if the test sees the value after the decrement. It provokes the second with `lk_i` set together with an always-taken option field. Here `lr_o` must carry `cia_i + 4` while `nia_o` must carry the old link value with its low bits cleared. The scoreboard checks every output field against a model that it builds from the requirements alone.

// File: rtl/brlr_pkg.sv
package brlr_pkg;
  localparam int BO_W = 5;
  localparam int LINK_STEP = 4;
  // option bit k (big-endian) lives at vector index BO_W-1-k
  localparam int OPT_COND_IGNORE = BO_W - 1 - 0;
  localparam int OPT_COND_SENSE  = BO_W - 1 - 1;
  localparam int OPT_CTR_KEEP    = BO_W - 1 - 2;
  localparam int OPT_CTR_ZERO    = BO_W - 1 - 3;
  localparam int OPT_HINT        = BO_W - 1 - 4;
endpackage

// File: rtl/brlr_ctr_eval.sv
module brlr_ctr_eval #(
  parameter int XLEN   = 64,
  parameter int NARROW = 32
) (
  input  logic [XLEN-1:0] ctr_i,
  input  logic            keep_i,
  input  logic            want_zero_i,
  input  logic            wide_i,
  output logic [XLEN-1:0] ctr_next_o,
  output logic            ok_o
);
  logic nz_wide;
  logic nz_narrow;
  logic nz;

  assign ctr_next_o = keep_i ? ctr_i : ctr_i - XLEN'(1);
  assign nz_wide    = |ctr_next_o;

  generate
    if (XLEN > NARROW) begin : g_split
      assign nz_narrow = |ctr_next_o[NARROW-1:0];
    end else begin : g_flat
      assign nz_narrow = nz_wide;
    end
  endgenerate

  assign nz   = wide_i ? nz_wide : nz_narrow;
  assign ok_o = keep_i | (nz ^ want_zero_i);
endmodule

// File: rtl/brlr_cond_eval.sv
module brlr_cond_eval #(
  parameter int CRW = 32,
  localparam int BIW = $clog2(CRW)
) (
  input  logic [CRW-1:0] cr_i,
  input  logic [BIW-1:0] bi_i,
  input  logic           ignore_i,
  input  logic           sense_i,
  output logic           ok_o
);
  localparam logic [BIW-1:0] TOP_IDX = BIW'(CRW - 1);
  logic [BIW-1:0] idx;
  logic           bit_sel;

  assign idx     = TOP_IDX - bi_i;
  assign bit_sel = cr_i[idx];
  assign ok_o    = ignore_i | (bit_sel == sense_i);
endmodule

// File: rtl/branch_lr_resolver.sv
module branch_lr_resolver
  import brlr_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CRW    = 32,
  parameter int NARROW = 32,
  localparam int BIW   = $clog2(CRW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BO_W-1:0]  bo_i,
  input  logic [BIW-1:0]   bi_i,
  input  logic             lk_i,
  input  logic             wide_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [CRW-1:0]   cr_i,
  input  logic [XLEN-1:0]  ctr_i,
  input  logic [XLEN-1:0]  lr_i,
  output logic [XLEN-1:0]  nia_o,
  output logic             taken_o,
  output logic [XLEN-1:0]  ctr_o,
  output logic             ctr_we_o,
  output logic [XLEN-1:0]  lr_o,
  output logic             lr_we_o
);
  logic [XLEN-1:0] ctr_next;
  logic            ctr_ok;
  logic            cond_ok;
  logic            take;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] target;
  logic            unused_hint;

  assign unused_hint = bo_i[OPT_HINT];

  brlr_ctr_eval #(.XLEN(XLEN), .NARROW(NARROW)) u_ctr (
    .ctr_i       (ctr_i),
    .keep_i      (bo_i[OPT_CTR_KEEP]),
    .want_zero_i (bo_i[OPT_CTR_ZERO]),
    .wide_i      (wide_i),
    .ctr_next_o  (ctr_next),
    .ok_o        (ctr_ok)
  );

  brlr_cond_eval #(.CRW(CRW)) u_cond (
    .cr_i     (cr_i),
    .bi_i     (bi_i),
    .ignore_i (bo_i[OPT_COND_IGNORE]),
    .sense_i  (bo_i[OPT_COND_SENSE]),
    .ok_o     (cond_ok)
  );

  assign take     = ctr_ok & cond_ok;
  assign seq_addr = cia_i + XLEN'(LINK_STEP);
  assign target   = {lr_i[XLEN-1:2], 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      nia_o    <= '0;
      taken_o  <= 1'b0;
      ctr_o    <= '0;
      ctr_we_o <= 1'b0;
      lr_o     <= '0;
      lr_we_o  <= 1'b0;
    end else begin
      nia_o    <= take ? target : seq_addr;
      taken_o  <= take;
      ctr_o    <= ctr_next;
      ctr_we_o <= ~bo_i[OPT_CTR_KEEP];
      lr_o     <= lk_i ? seq_addr : lr_i;
      lr_we_o  <= lk_i;
    end
  end
endmodule

// File: rtl/brlr_checker.sv
module brlr_checker #(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  parameter int BIW  = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [4:0]      bo_i,
  input logic [BIW-1:0]  bi_i,
  input logic            lk_i,
  input logic            wide_i,
  input logic [XLEN-1:0] cia_i,
  input logic [CRW-1:0]  cr_i,
  input logic [XLEN-1:0] ctr_i,
  input logic [XLEN-1:0] lr_i,
  input logic [XLEN-1:0] nia_o,
  input logic            taken_o,
  input logic [XLEN-1:0] ctr_o,
  input logic            ctr_we_o,
  input logic [XLEN-1:0] lr_o,
  input logic            lr_we_o
);
  assert_ctr_dec_R1: assert property (@(posedge clk) disable iff (rst)
    !bo_i[2] |=> (ctr_we_o && ctr_o == $past(ctr_i) - XLEN'(1)));

  assert_ctr_keep_R11: assert property (@(posedge clk) disable iff (rst)
    bo_i[2] |=> (!ctr_we_o && ctr_o == $past(ctr_i)));

  assert_target_align_R6: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (nia_o[1:0] == 2'b00));

  assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (taken_o || nia_o == $past(cia_i) + XLEN'(4)));

  assert_link_write_R8: assert property (@(posedge clk) disable iff (rst)
    lk_i |=> (lr_we_o && lr_o == $past(cia_i) + XLEN'(4)));

  assert_old_link_R9: assert property (@(posedge clk) disable iff (rst)
    (lk_i && bo_i[4] && bo_i[2]) |=> (taken_o && nia_o == {$past(lr_i[XLEN-1:2]), 2'b00}));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (nia_o == '0 && !taken_o && ctr_o == '0 && !ctr_we_o && lr_o == '0 && !lr_we_o));
endmodule

bind branch_lr_resolver brlr_checker #(.XLEN(XLEN), .CRW(CRW), .BIW(BIW)) u_brlr_chk (.*);

// File: tb/tb_branch_lr_resolver.sv
module tb_branch_lr_resolver;
  typedef struct {
    logic [63:0] nia;
    logic        taken;
    logic [63:0] ctr;
    logic        ctr_we;
    logic [63:0] lr;
    logic        lr_we;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [4:0]  bo_i = '0;
  logic [4:0]  bi_i = '0;
  logic        lk_i = 0;
  logic        wide_i = 1;
  logic [63:0] cia_i = '0;
  logic [31:0] cr_i = '0;
  logic [63:0] ctr_i = '0;
  logic [63:0] lr_i = '0;
  logic [63:0] nia_o, ctr_o, lr_o;
  logic        taken_o, ctr_we_o, lr_we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  branch_lr_resolver dut (
    .clk(clk), .rst(rst), .bo_i(bo_i), .bi_i(bi_i), .lk_i(lk_i), .wide_i(wide_i),
    .cia_i(cia_i), .cr_i(cr_i), .ctr_i(ctr_i), .lr_i(lr_i),
    .nia_o(nia_o), .taken_o(taken_o), .ctr_o(ctr_o), .ctr_we_o(ctr_we_o),
    .lr_o(lr_o), .lr_we_o(lr_we_o)
  );

  task automatic drive(input logic [4:0] bo, input logic [4:0] bi, input logic lk,
                       input logic wide, input logic [63:0] cia, input logic [31:0] cr,
                       input logic [63:0] ctr, input logic [63:0] lr, input string tag);
    exp_t e;
    logic [63:0] c;
    logic nz, cok, qok, crb;
    @(negedge clk);
    bo_i = bo; bi_i = bi; lk_i = lk; wide_i = wide;
    cia_i = cia; cr_i = cr; ctr_i = ctr; lr_i = lr;
    c = bo[2] ? ctr : ctr - 64'd1;                      // R1, R11
    nz = wide ? (c != 0) : (c[31:0] != 0);              // R2
    cok = bo[2] | (nz ^ bo[1]);                         // R3
    crb = cr[31 - int'(bi)];
    qok = bo[4] | (crb == bo[3]);                       // R4
    e.taken = cok & qok;                                // R5
    e.nia = e.taken ? (lr & ~64'd3) : cia + 64'd4;      // R6 R7 R9
    e.ctr = c;
    e.ctr_we = ~bo[2];
    e.lr = lk ? cia + 64'd4 : lr;                       // R8
    e.lr_we = lk;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (nia_o !== e.nia || taken_o !== e.taken || ctr_o !== e.ctr ||
            ctr_we_o !== e.ctr_we || lr_o !== e.lr || lr_we_o !== e.lr_we) begin
          n_bad++;
          $display("FAIL %s: got nia=%h tk=%b ctr=%h cwe=%b lr=%h lwe=%b exp nia=%h tk=%b ctr=%h cwe=%b lr=%h lwe=%b",
                   e.tag, nia_o, taken_o, ctr_o, ctr_we_o, lr_o, lr_we_o,
                   e.nia, e.taken, e.ctr, e.ctr_we, e.lr, e.lr_we);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    n_chk++;  // R10 reset state
    if (nia_o !== 0 || taken_o !== 0 || ctr_o !== 0 || ctr_we_o !== 0 || lr_o !== 0 || lr_we_o !== 0) begin
      n_bad++;
      $display("FAIL R10: got nia=%h ctr=%h lr=%h exp all zero", nia_o, ctr_o, lr_o);
    end
    @(negedge clk); rst = 0;
    // R5 R6: always-taken option field, low bits of LR cleared
    drive(5'b10100, 5'd0, 0, 1, 64'h1000, 32'h0, 64'h55, 64'hDEAD_BEEF_0000_1237, "R5_R6_always");
    // R4: condition bit 0 is cr[31], sense 1
    drive(5'b01100, 5'd0, 0, 1, 64'h2000, 32'h8000_0000, 64'h9, 64'h400, "R4_bit0_set");
    drive(5'b01100, 5'd0, 0, 1, 64'h2000, 32'h7FFF_FFFF, 64'h9, 64'h400, "R4_bit0_clear");
    drive(5'b00100, 5'd31, 0, 1, 64'h2000, 32'h0000_0000, 64'h9, 64'h404, "R4_bit31_sense0");
    drive(5'b00100, 5'd31, 0, 1, 64'h2000, 32'h0000_0001, 64'h9, 64'h404, "R4_bit31_miss");
    // R1 R3: decrement then test
    drive(5'b10000, 5'd0, 0, 1, 64'h3000, 32'h0, 64'd1, 64'h800, "R1_R3_dec_to_zero");
    drive(5'b10000, 5'd0, 0, 1, 64'h3000, 32'h0, 64'd2, 64'h800, "R1_R3_dec_nonzero");
    drive(5'b10010, 5'd0, 0, 1, 64'h3000, 32'h0, 64'd1, 64'h800, "R3_branch_on_zero");
    drive(5'b10000, 5'd0, 0, 1, 64'h3000, 32'h0, 64'd0, 64'h800, "R1_wrap");
    // R2: narrow vs wide test of the decremented value
    drive(5'b10000, 5'd0, 0, 1, 64'h4000, 32'h0, 64'h1_0000_0001, 64'hC00, "R2_wide");
    drive(5'b10000, 5'd0, 0, 0, 64'h4000, 32'h0, 64'h1_0000_0001, 64'hC00, "R2_narrow");
    // R7: not taken fall-through
    drive(5'b00000, 5'd3, 0, 1, 64'hFFFF_FFFF_FFFF_FFFC, 32'h1000_0000, 64'h5, 64'h10, "R7_fallthrough");
    // R8 R9: link with taken and not taken
    drive(5'b10100, 5'd0, 1, 1, 64'h5000, 32'h0, 64'h7, 64'hABCD_0002, "R8_R9_taken_link");
    drive(5'b00100, 5'd2, 1, 1, 64'h5000, 32'h2000_0000, 64'h7, 64'hABCD_0002, "R8_nottaken_link");
    // R11: no decrement, no link
    drive(5'b10110, 5'd0, 0, 0, 64'h6000, 32'h0, 64'h0, 64'h1234, "R11_keep");
    // mixed stimulus covering all requirements
    for (int i = 0; i < 300; i++) begin
      drive(5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, $urandom,
            (i % 3 == 0) ? 64'($urandom_range(0, 2)) : {$urandom, $urandom},
            {$urandom, $urandom}, "R1_R11_mixed");
    end
    // R10: reset mid-run clears everything
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    n_chk++;
    if (nia_o !== 0 || taken_o !== 0 || ctr_o !== 0 || lr_o !== 0 || ctr_we_o !== 0 || lr_we_o !== 0) begin
      n_bad++;
      $display("FAIL R10: got nia=%h ctr=%h lr=%h exp all zero", nia_o, ctr_o, lr_o);
    end
    q.delete();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule